// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that paces a successive-approximation converter between its acquire and convert phases. Analog timing is replaced by clock-cycle counts. An active-low start strobe begins a conversion. BUSY stays high for a fixed number of convert cycles, and at the end of that window a result word taken from a stub sample input is latched.

Once a conversion has begun it always runs to completion. Neither a repeated strobe nor a power-down request can cut it short. Three operating modes are selectable. In the low-power impulse mode, the analog core enable is dropped whenever the block is not converting. In the same mode, a strobe that stays low makes the block restart conversions on its own after each minimum acquisition window. The strobe must still fall once after reset before anything happens.

Top module: `adc_conv_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the block goes to the acquire state: busy is 0 and data_out is 0. After reset in a non-impulse mode, core_en is 1.
- R2: The start strobe is synchronised through two flip-flops. When start_n goes low after the acquisition minimum has elapsed, busy is 1 from the third rising clock edge after the change. busy then stays high for exactly CONV_CYC cycles.
- R3: A conversion cannot be restarted or aborted. A strobe edge during busy neither alters the busy width nor causes a further conversion.
- R4: Asserting pwr_dn during a conversion does not shorten it. When busy falls with pwr_dn high, the block enters power-down: core_en is 0 and strobes are ignored. Releasing pwr_dn returns the block to acquire with core_en 1 in a non-impulse mode.
- R5: At the last convert cycle, data_out takes the value of sample_in. At all other times it holds its value, even when sample_in changes.
- R6: In impulse mode (mode = 2'b10), if start_n is held low, conversions repeat with no further edges. busy is low for exactly ACQ_MIN+1 cycles between them. The repetition stops once start_n is high.
- R7: In normal mode (2'b00), warp mode (2'b01) and the unused code 2'b11, a start_n held low gives exactly one conversion. Each further conversion needs a new falling edge.
- R8: After reset, no conversion occurs until start_n has gone from high to low. This holds in impulse mode too, when start_n is low through reset.
- R9: In impulse mode, core_en is 1 during every convert cycle and 0 during every acquire cycle.
- R10: A falling edge that is detected before ACQ_MIN cycles of acquisition have elapsed is held pending. Its conversion starts when the minimum expires, so busy is low for exactly ACQ_MIN+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Asynchronous active-low conversion start strobe |
| pwr_dn | input | 1 | Power-down request, honoured only outside conversion |
| mode | input | 2 | 00 normal, 01 warp, 10 impulse, 11 treated as normal |
| sample_in | input | DW | Stub conversion value latched at the end of conversion |
| busy | output | 1 | High while a conversion is running |
| core_en | output | 1 | Analog core enable |
| data_out | output | DW | Latched result word |

## Verification
Two events can land in the same clock: the last convert cycle and a power-down request, or a pending manual start and the expiry of the acquisition minimum.

The bench raises pwr_dn in the middle of a conversion. It judges the result by the busy width measured at the ports and by core_en once busy falls.

It also lowers the strobe on the very cycle BUSY falls, so that the detected edge lands inside the acquisition minimum. The resulting low gap on busy must equal ACQ_MIN+1, the same value as for the self-restart in impulse mode.

// File: rtl/adc_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes: mode codes are fixed by the port definition; 2'b11 behaves as normal.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_WARP    = 2'b01,
        MODE_IMPULSE = 2'b10
    } op_mode_e;

    typedef enum logic [1:0] {
        ST_ACQ  = 2'b00,
        ST_CONV = 2'b01,
        ST_DOWN = 2'b10
    } seq_state_e;
endpackage

// File: rtl/adc_strobe_sync.sv
// Two-flop synchroniser for the asynchronous start strobe, plus falling-edge detect.
// Assumes: flops reset to the "low" value, so a strobe held low through reset
// yields no edge; a real high-to-low transition is required (R8).
module adc_strobe_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic strobe_low,
    output logic strobe_fall
);
    logic meta_q, sync_q, prev_q;

    // Synchronise the strobe and keep one older sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= start_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Level and falling-edge views of the synchronised strobe.
    always_comb begin
        strobe_low  = ~sync_q;
        strobe_fall = prev_q & ~sync_q;
    end

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_fall |=> !strobe_fall); // R2
endmodule

// File: rtl/adc_phase_timer.sv
// Cycle counters standing in for analog timing: convert window length and
// minimum acquisition length.
// Assumes: CONV_CYC >= 2 and ACQ_MIN >= 1; in_conv comes from the sequencer state.
module adc_phase_timer #(
    parameter int CONV_CYC = 32,
    parameter int ACQ_MIN  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_conv,
    output logic conv_last,
    output logic acq_done
);
    localparam int CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
    localparam int AW = $clog2(ACQ_MIN + 1);
    localparam logic [CW-1:0] CONV_END = CW'(CONV_CYC - 1);
    localparam logic [AW-1:0] ACQ_END  = AW'(ACQ_MIN);

    logic [CW-1:0] conv_cnt;
    logic [AW-1:0] acq_cnt;

    // Count convert cycles; cleared whenever the sequencer is not converting.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_conv) conv_cnt <= '0;
        else if (conv_cnt != CONV_END) conv_cnt <= conv_cnt + 1'b1;
    end

    // Count non-converting cycles, saturating at the acquisition minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || in_conv) acq_cnt <= '0;
        else if (acq_cnt != ACQ_END) acq_cnt <= acq_cnt + 1'b1;
    end

    // Phase boundary flags for the sequencer.
    always_comb begin
        conv_last = in_conv && (conv_cnt == CONV_END);
        acq_done  = !in_conv && (acq_cnt == ACQ_END);
    end

    AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_conv) |-> $past(conv_last)); // R3
endmodule

// File: rtl/adc_result_latch.sv
// Holds the stub result word; loads only on the final convert cycle.
// Assumes: load is a single-cycle pulse from the phase timer.
module adc_result_latch #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    // Capture the sample at end of conversion, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout)); // R5
endmodule

// File: rtl/adc_conv_seq.sv
// Conversion control sequencer: acquire / convert / power-down state machine.
// Assumes: start_n is asynchronous; pwr_dn and mode are synchronous to clk.
// A conversion, once entered, always completes; power-down is applied only
// after busy falls; impulse mode self-restarts while the strobe stays low.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CONV_CYC = 32,
    parameter int ACQ_MIN  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_n,
    input  logic          pwr_dn,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] sample_in,
    output logic          busy,
    output logic          core_en,
    output logic [DW-1:0] data_out
);
    seq_state_e state_q, state_nx;
    logic strobe_low, strobe_fall;
    logic conv_last, acq_done;
    logic pend_q, armed_q;
    logic is_impulse, auto_go, start_go;

    adc_strobe_sync u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_n     (start_n),
        .strobe_low  (strobe_low),
        .strobe_fall (strobe_fall)
    );

    adc_phase_timer #(.CONV_CYC(CONV_CYC), .ACQ_MIN(ACQ_MIN)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_conv   (state_q == ST_CONV),
        .conv_last (conv_last),
        .acq_done  (acq_done)
    );

    adc_result_latch #(.DW(DW)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (conv_last),
        .din   (sample_in),
        .dout  (data_out)
    );

    // Start qualification: manual edge (now or pending) or impulse self-restart.
    always_comb begin
        is_impulse = (mode == MODE_IMPULSE);
        auto_go    = is_impulse && armed_q && strobe_low;
        start_go   = acq_done && (pend_q || strobe_fall || auto_go);
    end

    // Next-state selection; convert is left only on its last cycle.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ACQ:  if (pwr_dn) state_nx = ST_DOWN;
                     else if (start_go) state_nx = ST_CONV;
            ST_CONV: if (conv_last) state_nx = pwr_dn ? ST_DOWN : ST_ACQ;
            ST_DOWN: if (!pwr_dn) state_nx = ST_ACQ;
            default: state_nx = ST_ACQ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACQ;
        else        state_q <= state_nx;
    end

    // Pending manual start: an edge seen in acquire before the minimum elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_ACQ || state_nx != ST_ACQ) pend_q <= 1'b0;
        else if (strobe_fall) pend_q <= 1'b1;
    end

    // Arm flag: set by the first strobe edge after reset, enables self-restart.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (strobe_fall) armed_q <= 1'b1;
    end

    // Outputs: busy in convert; core enable depends on mode and phase.
    always_comb begin
        busy    = (state_q == ST_CONV);
        core_en = (state_q == ST_CONV) || ((state_q == ST_ACQ) && !is_impulse);
    end

    AST_ENTRY_AFTER_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acq_done)); // R10
    AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_last) |=> busy); // R3
    AST_PD_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pwr_dn && !conv_last) |=> busy); // R4
    AST_ARMED_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> armed_q); // R8
    AST_IMPULSE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && is_impulse) |-> !core_en); // R9
endmodule

// File: tb/adc_conv_seq_tb_top.sv
// Scoreboard bench: test tasks push expected result words into a queue; a
// monitor measures busy pulses and gaps and pops/compares on each busy fall.
module adc_conv_seq_tb_top;
    localparam int DW       = 16;
    localparam int CONV_CYC = 8;
    localparam int ACQ_MIN  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_n = 1'b1;
    logic          pwr_dn = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [DW-1:0] sample_in = '0;
    logic          busy, core_en;
    logic [DW-1:0] data_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic [DW-1:0] exp_q[$];
    int conv_cnt = 0;
    int hi_len = 0;
    int lo_len = 0;
    int last_gap = 0;
    logic prev_busy = 1'b0;

    adc_conv_seq #(.DW(DW), .CONV_CYC(CONV_CYC), .ACQ_MIN(ACQ_MIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_dn(pwr_dn),
        .mode(mode), .sample_in(sample_in), .busy(busy), .core_en(core_en),
        .data_out(data_out)
    );

    always #10 clk = ~clk; // 50 MHz

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_conv(input int target);
        while (conv_cnt < target) tick();
    endtask

    // Monitor: measure busy width and gaps, score result words on busy fall.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_busy = 1'b0; hi_len = 0; lo_len = 0;
        end else begin
            if (busy) begin
                if (!prev_busy) last_gap = lo_len;
                hi_len++;
                lo_len = 0;
            end else begin
                if (prev_busy) begin
                    check(hi_len == CONV_CYC, "R2 busy width", hi_len, CONV_CYC);
                    if (exp_q.size() == 0)
                        check(1'b0, "R3 unexpected conversion", 1, 0);
                    else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        check(data_out == e, "R5 result word", data_out, e);
                    end
                    conv_cnt++;
                    hi_len = 0;
                end
                lo_len++;
            end
            prev_busy = busy;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R2 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        int bad;
        // R1: reset state in normal mode
        repeat (3) tick();
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(data_out == '0, "R1 data after reset", data_out, 0);
        check(core_en == 1'b1, "R1 core_en after reset", core_en, 1);
        rst_n = 1'b1;
        repeat (10) tick();
        check(busy == 1'b0, "R8 no conversion without strobe edge", busy, 0);

        // R2: latency and width of a manual conversion
        sample_in = 16'hA5A5;
        exp_q.push_back(16'hA5A5);
        base = conv_cnt;
        start_n = 1'b0;
        repeat (2) tick();
        check(busy == 1'b0, "R2 busy before third edge", busy, 0);
        tick();
        check(busy == 1'b1, "R2 busy at third edge", busy, 1);
        wait_conv(base + 1);
        // R5: data holds while sample_in moves; R7: held low gives one conversion
        sample_in = 16'hFFFF;
        repeat (30) tick();
        check(data_out == 16'hA5A5, "R5 data held", data_out, 16'hA5A5);
        check(conv_cnt == base + 1, "R7 normal held low", conv_cnt - base, 1);
        start_n = 1'b1;
        repeat (4) tick();

        // R3: strobe edge inside a conversion is ignored
        sample_in = 16'h0F0F;
        exp_q.push_back(16'h0F0F);
        base = conv_cnt;
        start_n = 1'b0;
        while (!busy) tick();
        repeat (2) tick();
        start_n = 1'b1;
        repeat (2) tick();
        start_n = 1'b0;
        wait_conv(base + 1);
        repeat (30) tick();
        check(conv_cnt == base + 1, "R3 no restart from mid-conversion edge", conv_cnt - base, 1);
        start_n = 1'b1;
        repeat (4) tick();

        // R7: warp mode held low
        mode = 2'b01;
        sample_in = 16'h3C3C;
        exp_q.push_back(16'h3C3C);
        base = conv_cnt;
        start_n = 1'b0;
        wait_conv(base + 1);
        repeat (30) tick();
        check(conv_cnt == base + 1, "R7 warp held low", conv_cnt - base, 1);

        // R10: edge inside the acquisition minimum is held off
        start_n = 1'b1;
        repeat (3) tick();
        mode = 2'b00;
        sample_in = 16'h1111;
        exp_q.push_back(16'h1111);
        base = conv_cnt;
        start_n = 1'b0;
        while (!busy) tick();
        start_n = 1'b1;
        wait_conv(base + 1);
        sample_in = 16'h2222;
        exp_q.push_back(16'h2222);
        start_n = 1'b0;
        while (!busy) tick();
        check(last_gap == ACQ_MIN + 1, "R10 held-off gap", last_gap, ACQ_MIN + 1);
        start_n = 1'b1;
        wait_conv(base + 2);
        repeat (6) tick();

        // R4: power-down during conversion is deferred
        sample_in = 16'h4444;
        exp_q.push_back(16'h4444);
        base = conv_cnt;
        start_n = 1'b0;
        while (!busy) tick();
        repeat (2) tick();
        pwr_dn = 1'b1;
        wait_conv(base + 1);
        check(core_en == 1'b0, "R4 core off in power-down", core_en, 0);
        start_n = 1'b1;
        repeat (3) tick();
        start_n = 1'b0;
        repeat (20) tick();
        check(conv_cnt == base + 1, "R4 strobe ignored in power-down", conv_cnt - base, 1);
        pwr_dn = 1'b0;
        repeat (2) tick();
        check(core_en == 1'b1, "R4 core on after release", core_en, 1);
        repeat (20) tick();
        check(conv_cnt == base + 1, "R7 no start without new edge", conv_cnt - base, 1);
        start_n = 1'b1;
        repeat (3) tick();
        sample_in = 16'h5555;
        exp_q.push_back(16'h5555);
        start_n = 1'b0;
        wait_conv(base + 2);
        check(data_out == 16'h5555, "R4 conversion after power-down", data_out, 16'h5555);
        start_n = 1'b1;
        repeat (6) tick();

        // R6/R9: impulse self-restart and core enable
        mode = 2'b10;
        tick();
        check(core_en == 1'b0, "R9 core off in impulse acquire", core_en, 0);
        sample_in = 16'h1234;
        repeat (3) exp_q.push_back(16'h1234);
        base = conv_cnt;
        bad = 0;
        start_n = 1'b0;
        while (conv_cnt < base + 3) begin
            tick();
            if (busy != core_en) bad++;
        end
        start_n = 1'b1;
        check(last_gap == ACQ_MIN + 1, "R6 self-restart gap", last_gap, ACQ_MIN + 1);
        check(bad == 0, "R9 core_en tracks busy in impulse", bad, 0);
        repeat (30) tick();
        check(conv_cnt == base + 3, "R6 restart stops after release", conv_cnt - base, 3);

        // R8: strobe low through reset in impulse mode never starts
        start_n = 1'b0;
        rst_n = 1'b0;
        repeat (3) tick();
        check(data_out == '0, "R1 data cleared by reset", data_out, 0);
        rst_n = 1'b1;
        base = conv_cnt;
        repeat (40) tick();
        check(conv_cnt == base, "R8 no run without edge", conv_cnt - base, 0);
        check(busy == 1'b0, "R8 busy idle", busy, 0);
        start_n = 1'b1;
        repeat (4) tick();
        check(exp_q.size() == 0, "R5 all results scored", exp_q.size(), 0);
        finish_run();
    end
endmodule